// File: doc/BRIEF.md
# NRZI Bit-Stuffing Line Coder

This block is the serial line stage of a low/full-speed USB-style link. On the transmit side it takes bytes over a valid/ready handshake and turns each packet into line symbols on a differential pair with an output-enable. The order is a start pattern, then the payload least significant bit first, with a zero forced in after every run of six ones, all NRZI coded, and then an end-of-packet sequence. On the receive side it samples a differential pair, undoes the NRZI coding, strips the start pattern and the stuffed zeros, and delivers bytes. It also flags end of packet, stuffing violations and a line held in the bus-reset state.

All sequential activity advances on a single-cycle bit enable, one per bit time, supplied by the surrounding logic. Line symbols use these codes: J = (dp=1, dm=0), K = (dp=0, dm=1), SE0 = (dp=0, dm=0).

Top module: `nrzi_line_coder`

## Requirements
- R1: After reset, and whenever the transmitter is not sending, tx_oe is 0 and the pair rests at J; tx_ready is 1 after reset.
- R2: A packet starts with eight start bits, seven 0s then a 1, coded from a J reference, so the first driven symbol is K. The payload bytes then follow, each sent bit 0 first.
- R3: NRZI coding: a 0 bit flips the line between J and K, and a 1 bit keeps the previous level.
- R4: After six consecutive 1 bits, counting the final 1 of the start pattern, the transmitter inserts a 0 bit. The run count restarts on any 0, including an inserted one.
- R5: If the final payload bit completes a run of six 1s, an inserted 0 is still sent before the end-of-packet sequence.
- R6: A packet ends with SE0 for two bit times, then J for one bit time with tx_oe still 1. After that tx_oe returns to 0.
- R7: A byte is taken when tx_valid and tx_ready are both 1 at a clock edge; tx_ready is 0 in the next cycle. tx_last marks the final byte of a packet.
- R8: tx_dp, tx_dm and tx_oe change only in the cycle after an edge at which bit_en was 1.
- R9: The receiver samples only when bit_en is 1. It strips the start pattern and assembles bytes bit 0 first, showing each on rx_data with a one-cycle rx_valid pulse.
- R10: A 0 bit received after six consecutive 1s is discarded and never becomes part of a byte.
- R11: A 1 bit received after six consecutive 1s gives a one-cycle rx_stuff_err pulse. Reception is then abandoned with no byte and no rx_eop until the line has gone through SE0 and back to J.
- R12: SE0 sampled during the payload of a packet gives a one-cycle rx_eop pulse.
- R13: rx_reset is 1 once SE0 has been sampled on RST_BITS consecutive bit times. It returns to 0 at the first sample that is not SE0. The two-bit SE0 of a normal end of packet never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per bit time |
| tx_data | input | DW | Byte to send |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_last | input | 1 | Byte is the last of its packet |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_dp | output | 1 | Transmit positive line |
| tx_dm | output | 1 | Transmit negative line |
| tx_oe | output | 1 | Transmit drivers enabled |
| rx_dp | input | 1 | Receive positive line |
| rx_dm | input | 1 | Receive negative line |
| rx_data | output | DW | Received byte |
| rx_valid | output | 1 | Pulse: rx_data is new |
| rx_eop | output | 1 | Pulse: end of packet seen |
| rx_stuff_err | output | 1 | Pulse: seven 1s in a row |
| rx_reset | output | 1 | Line held in SE0 for RST_BITS bit times |

## Verification
All-ones payloads force stuffing inside and across byte boundaries, so the run count must carry over both the start pattern's final 1 and the byte boundary. A coder that misses this sends seven unbroken 1s or stuffs one bit late. A payload ending in six 1s exposes a transmitter that jumps to SE0 without the trailing inserted zero. In loopback the same stream shows whether the receiver discards that zero, or keeps it and shifts every later byte. Directly driven lines check that seven 1s abort reception without a stray byte or end flag, and that rx_reset rises on exactly the sixteenth SE0 sample and not one bit early.

// File: rtl/nrzi_line_pkg.sv
package nrzi_line_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ACT,
        TX_TAIL,
        TX_EOP2,
        TX_EOPJ
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_HUNT,
        RX_DATA,
        RX_ERR,
        RX_WAITJ
    } rx_state_e;
endpackage

// File: rtl/nrzi_tx_path.sv
module nrzi_tx_path
    import nrzi_line_pkg::*;
#(
    parameter int DW      = 8,
    parameter int RUN_MAX = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    input  logic          tx_last,
    output logic          tx_ready,
    output logic          tx_dp,
    output logic          tx_dm,
    output logic          tx_oe
);
    localparam int CNT_W = (DW > 1) ? $clog2(DW) : 1;
    localparam int RUN_W = $clog2(RUN_MAX + 1);
    localparam logic [DW-1:0] START_PAT = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        tx_state_e         st;
        logic [DW-1:0]     shift;
        logic [CNT_W-1:0]  bitc;
        logic [RUN_W-1:0]  ones;
        logic              cur_last;
        logic [DW-1:0]     hold;
        logic              hold_last;
        logic              hold_full;
        logic              level;
        logic              dp;
        logic              dm;
        logic              oe;
    } tx_reg_t;

    tx_reg_t tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        // holding register: filled only when empty, drained only when full
        if (tx_valid && !tx_q.hold_full) begin
            tx_d.hold      = tx_data;
            tx_d.hold_last = tx_last;
            tx_d.hold_full = 1'b1;
        end
        if (bit_en) begin
            case (tx_q.st)
                TX_IDLE: begin
                    tx_d.dp    = 1'b1;
                    tx_d.dm    = 1'b0;
                    tx_d.oe    = 1'b0;
                    tx_d.level = 1'b1;
                    tx_d.ones  = '0;
                    if (tx_q.hold_full) begin
                        tx_d.st       = TX_ACT;
                        tx_d.shift    = START_PAT;
                        tx_d.bitc     = '0;
                        tx_d.cur_last = 1'b0;
                    end
                end
                TX_ACT: begin
                    if (tx_q.ones == RUN_W'(RUN_MAX)) begin
                        tx_d.level = ~tx_q.level;
                        tx_d.ones  = '0;
                    end else begin
                        tx_d.level = tx_q.shift[0] ? tx_q.level : ~tx_q.level;
                        tx_d.ones  = tx_q.shift[0] ? tx_q.ones + 1'b1 : '0;
                        tx_d.shift = tx_q.shift >> 1;
                        tx_d.bitc  = tx_q.bitc + 1'b1;
                        if (tx_q.bitc == CNT_W'(DW-1)) begin
                            tx_d.bitc = '0;
                            if (!tx_q.cur_last && tx_q.hold_full) begin
                                tx_d.shift     = tx_q.hold;
                                tx_d.cur_last  = tx_q.hold_last;
                                tx_d.hold_full = 1'b0;
                            end else begin
                                tx_d.st = TX_TAIL;
                            end
                        end
                    end
                    tx_d.dp = tx_d.level;
                    tx_d.dm = ~tx_d.level;
                    tx_d.oe = 1'b1;
                end
                TX_TAIL: begin
                    tx_d.oe = 1'b1;
                    if (tx_q.ones == RUN_W'(RUN_MAX)) begin
                        tx_d.level = ~tx_q.level;
                        tx_d.ones  = '0;
                        tx_d.dp    = ~tx_q.level;
                        tx_d.dm    = tx_q.level;
                    end else begin
                        tx_d.dp = 1'b0;
                        tx_d.dm = 1'b0;
                        tx_d.st = TX_EOP2;
                    end
                end
                TX_EOP2: begin
                    tx_d.dp = 1'b0;
                    tx_d.dm = 1'b0;
                    tx_d.oe = 1'b1;
                    tx_d.st = TX_EOPJ;
                end
                default: begin
                    tx_d.dp    = 1'b1;
                    tx_d.dm    = 1'b0;
                    tx_d.oe    = 1'b1;
                    tx_d.level = 1'b1;
                    tx_d.st    = TX_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q       <= '0;
            tx_q.st    <= TX_IDLE;
            tx_q.level <= 1'b1;
            tx_q.dp    <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_ready = !tx_q.hold_full;
    assign tx_dp    = tx_q.dp;
    assign tx_dm    = tx_q.dm;
    assign tx_oe    = tx_q.oe;
endmodule

// File: rtl/nrzi_rx_path.sv
module nrzi_rx_path
    import nrzi_line_pkg::*;
#(
    parameter int DW       = 8,
    parameter int RUN_MAX  = 6,
    parameter int RST_BITS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          rx_dp,
    input  logic          rx_dm,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_eop,
    output logic          rx_stuff_err,
    output logic          rx_reset
);
    localparam int CNT_W = (DW > 1) ? $clog2(DW) : 1;
    localparam int RUN_W = $clog2(RUN_MAX + 1);
    localparam int RST_W = $clog2(RST_BITS + 1);

    typedef struct packed {
        rx_state_e         st;
        logic              prev;
        logic [RUN_W-1:0]  ones;
        logic [CNT_W-1:0]  bitc;
        logic [DW-1:0]     shift;
        logic [RST_W-1:0]  se0_cnt;
        logic [DW-1:0]     data;
        logic              valid;
        logic              eop;
        logic              err;
        logic              rst;
    } rx_reg_t;

    rx_reg_t rx_q, rx_d;
    logic    se0;
    logic    dbit;

    assign se0  = !rx_dp && !rx_dm;
    assign dbit = (rx_dp == rx_q.prev);

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.eop   = 1'b0;
        rx_d.err   = 1'b0;
        if (bit_en) begin
            if (!se0)
                rx_d.se0_cnt = '0;
            else if (rx_q.se0_cnt != RST_W'(RST_BITS))
                rx_d.se0_cnt = rx_q.se0_cnt + 1'b1;
            rx_d.rst = (rx_d.se0_cnt == RST_W'(RST_BITS));
            case (rx_q.st)
                RX_IDLE: begin
                    rx_d.prev = 1'b1;
                    if (!se0 && !rx_dp) begin
                        rx_d.st   = RX_HUNT;
                        rx_d.prev = 1'b0;
                    end
                end
                RX_HUNT: begin
                    if (se0) begin
                        rx_d.st = RX_WAITJ;
                    end else begin
                        rx_d.prev = rx_dp;
                        if (dbit) begin
                            rx_d.st   = RX_DATA;
                            rx_d.ones = RUN_W'(1);
                            rx_d.bitc = '0;
                        end
                    end
                end
                RX_DATA: begin
                    if (se0) begin
                        rx_d.eop = 1'b1;
                        rx_d.st  = RX_WAITJ;
                    end else begin
                        rx_d.prev = rx_dp;
                        if (rx_q.ones == RUN_W'(RUN_MAX)) begin
                            if (dbit) begin
                                rx_d.err = 1'b1;
                                rx_d.st  = RX_ERR;
                            end else begin
                                rx_d.ones = '0;
                            end
                        end else begin
                            rx_d.shift = {dbit, rx_q.shift[DW-1:1]};
                            rx_d.ones  = dbit ? rx_q.ones + 1'b1 : '0;
                            rx_d.bitc  = rx_q.bitc + 1'b1;
                            if (rx_q.bitc == CNT_W'(DW-1)) begin
                                rx_d.bitc  = '0;
                                rx_d.valid = 1'b1;
                                rx_d.data  = {dbit, rx_q.shift[DW-1:1]};
                            end
                        end
                    end
                end
                RX_ERR: begin
                    if (se0) rx_d.st = RX_WAITJ;
                end
                default: begin
                    if (!se0 && rx_dp) begin
                        rx_d.st   = RX_IDLE;
                        rx_d.prev = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_q.st   <= RX_IDLE;
            rx_q.prev <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_data      = rx_q.data;
    assign rx_valid     = rx_q.valid;
    assign rx_eop       = rx_q.eop;
    assign rx_stuff_err = rx_q.err;
    assign rx_reset     = rx_q.rst;
endmodule

// File: rtl/nrzi_line_coder.sv
module nrzi_line_coder #(
    parameter int DW       = 8,
    parameter int RUN_MAX  = 6,
    parameter int RST_BITS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    input  logic          tx_last,
    output logic          tx_ready,
    output logic          tx_dp,
    output logic          tx_dm,
    output logic          tx_oe,
    input  logic          rx_dp,
    input  logic          rx_dm,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_eop,
    output logic          rx_stuff_err,
    output logic          rx_reset
);
    nrzi_tx_path #(.DW(DW), .RUN_MAX(RUN_MAX)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .tx_dp    (tx_dp),
        .tx_dm    (tx_dm),
        .tx_oe    (tx_oe)
    );

    nrzi_rx_path #(.DW(DW), .RUN_MAX(RUN_MAX), .RST_BITS(RST_BITS)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .rx_dp        (rx_dp),
        .rx_dm        (rx_dm),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_eop       (rx_eop),
        .rx_stuff_err (rx_stuff_err),
        .rx_reset     (rx_reset)
    );
endmodule

// File: rtl/nrzi_line_coder_chk.sv
module nrzi_line_coder_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_dp,
    input logic tx_dm,
    input logic tx_oe,
    input logic rx_dp,
    input logic rx_dm,
    input logic rx_valid,
    input logic rx_eop,
    input logic rx_stuff_err,
    input logic rx_reset
);
    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable({tx_dp, tx_dm, tx_oe}));

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> (tx_dp && !tx_dm));

    // R7
    accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R2
    start_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> (!tx_dp && tx_dm));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R12
    eop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eop |=> !rx_eop);

    // R11
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuff_err |-> (!rx_valid && !rx_eop));

    // R13
    rst_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_reset) |-> $past(!rx_dp && !rx_dm));
endmodule

bind nrzi_line_coder nrzi_line_coder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_dp        (tx_dp),
    .tx_dm        (tx_dm),
    .tx_oe        (tx_oe),
    .rx_dp        (rx_dp),
    .rx_dm        (rx_dm),
    .rx_valid     (rx_valid),
    .rx_eop       (rx_eop),
    .rx_stuff_err (rx_stuff_err),
    .rx_reset     (rx_reset)
);

// File: tb/nrzi_line_coder_test.sv
module nrzi_line_coder_test;
    localparam int RST = 16;
    localparam int WD  = 150000;
    localparam logic [1:0] SJ = 2'b10, SK = 2'b01, S0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0, tx_last = 1'b0;
    logic       tx_ready, tx_dp, tx_dm, tx_oe;
    logic       loop = 1'b1;
    logic       drv_dp = 1'b1, drv_dm = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_eop, rx_stuff_err, rx_reset;

    nrzi_line_coder #(.DW(8), .RUN_MAX(6), .RST_BITS(RST)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .tx_dp(tx_dp), .tx_dm(tx_dm), .tx_oe(tx_oe),
        .rx_dp(loop ? tx_dp : drv_dp), .rx_dm(loop ? tx_dm : drv_dm),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_eop(rx_eop),
        .rx_stuff_err(rx_stuff_err), .rx_reset(rx_reset)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, div = 0;
    logic [1:0] exp_sym[$];
    int         exp_req[$];
    logic [7:0] pkt_q[$];
    logic [7:0] got_rx[$];
    logic [1:0] drv_q[$];
    int  eop_n = 0, err_n = 0, rst_seen = 0;
    logic was_oe = 1'b0;
    logic [2:0] last_tx = 3'b100;
    event upd;

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected line symbols from the requirements: start bits (R2), payload (R3),
    // inserted zeros (R4), trailing inserted zero (R5), end sequence (R6)
    task automatic build_tx();
        bit bits[$];
        int tags[$];
        int run = 0;
        bit lvl = 1'b1;
        exp_sym.delete(); exp_req.delete();
        for (int i = 0; i < 8; i++) begin bits.push_back(i == 7); tags.push_back(2); end
        foreach (pkt_q[k]) for (int i = 0; i < 8; i++) begin bits.push_back(pkt_q[k][i]); tags.push_back(3); end
        foreach (bits[i]) begin
            if (run == 6) begin
                lvl = ~lvl; run = 0;
                exp_sym.push_back(lvl ? SJ : SK); exp_req.push_back(4);
            end
            if (!bits[i]) lvl = ~lvl;
            run = bits[i] ? run + 1 : 0;
            exp_sym.push_back(lvl ? SJ : SK); exp_req.push_back(tags[i]);
        end
        if (run == 6) begin
            lvl = ~lvl;
            exp_sym.push_back(lvl ? SJ : SK); exp_req.push_back(5);
        end
        exp_sym.push_back(S0); exp_req.push_back(6);
        exp_sym.push_back(S0); exp_req.push_back(6);
        exp_sym.push_back(SJ); exp_req.push_back(6);
    endtask

    task automatic run_packet(input string rq);
        build_tx();
        got_rx.delete(); eop_n = 0; err_n = 0; rst_seen = 0; loop = 1'b1;
        foreach (pkt_q[i]) begin
            @(negedge clk);
            tx_valid = 1'b1; tx_data = pkt_q[i]; tx_last = (i == pkt_q.size() - 1);
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
            // R7: accepted byte occupies the holding slot
            chk(!tx_ready, "R7", tx_ready, 0, "ready after accept");
        end
        while (exp_sym.size() != 0 || tx_oe) @(negedge clk);
        repeat (40) @(negedge clk);
        // R9 / R10: bytes recovered in order
        chk(got_rx.size() == pkt_q.size(), rq, got_rx.size(), pkt_q.size(), "rx byte count");
        foreach (pkt_q[i]) if (i < got_rx.size())
            chk(got_rx[i] == pkt_q[i], rq, got_rx[i], pkt_q[i], "rx byte");
        chk(eop_n == 1, "R12", eop_n, 1, "rx end pulses");
        chk(err_n == 0, "R11", err_n, 0, "rx stuff errors");
        chk(rst_seen == 0, "R13", rst_seen, 0, "reset during end sequence");
    endtask

    task automatic drive_rx();
        loop = 1'b0;
        foreach (drv_q[i]) begin
            @(upd);
            {drv_dp, drv_dm} = drv_q[i];
        end
    endtask

    // bit_en generation and per-clock comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WD) begin
                checks++; fails++;
                $display("FAIL R8 watchdog: actual=%0d expected=%0d", cyc, WD);
                $display("test done: total=%0d bad=%0d", checks, fails);
                $finish;
            end
            if (rst_n && bit_en) begin
                if (tx_oe) begin
                    if (exp_sym.size() == 0) begin
                        chk(0, "R6", 1, 0, "drivers on after packet");
                    end else begin
                        logic [1:0] s;
                        int r;
                        s = exp_sym.pop_front(); r = exp_req.pop_front();
                        chk({tx_dp, tx_dm} == s, $sformatf("R%0d", r), {tx_dp, tx_dm}, s, "line symbol");
                    end
                end else if (was_oe && exp_sym.size() != 0) begin
                    chk(0, "R6", exp_sym.size(), 0, "drivers off early");
                end
                was_oe = tx_oe;
                if (rx_valid) got_rx.push_back(rx_data);
                if (rx_eop) eop_n++;
                if (rx_stuff_err) err_n++;
                if (rx_reset) rst_seen++;
                -> upd;
            end else if (rst_n) begin
                // R8: nothing moves between bit times
                if ({tx_dp, tx_dm, tx_oe} != last_tx)
                    chk(0, "R8", {tx_dp, tx_dm, tx_oe}, last_tx, "output moved off bit time");
                if (rx_valid || rx_eop || rx_stuff_err)
                    chk(0, "R9", 1, 0, "rx pulse off bit time");
            end
            last_tx = {tx_dp, tx_dm, tx_oe};
            bit_en = (div == 3);
            div = (div + 1) % 4;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(tx_oe == 0, "R1", tx_oe, 0, "oe after reset");
        chk({tx_dp, tx_dm} == SJ, "R1", {tx_dp, tx_dm}, SJ, "idle level");
        chk(tx_ready == 1, "R1", tx_ready, 1, "ready after reset");
        chk(rx_valid == 0 && rx_reset == 0, "R1", {rx_valid, rx_reset}, 0, "rx quiet after reset");

        // R2 R3: mixed payload
        pkt_q = {8'hA5, 8'h3C, 8'h00};
        run_packet("R9");
        // R4 R10: stuffing inside and across bytes
        pkt_q = {8'hFF, 8'hFF, 8'h7F};
        run_packet("R10");
        // R5: last bit closes a run of six ones
        pkt_q = {8'hFC};
        run_packet("R5");

        // R11: seven ones after the start pattern
        begin
            bit lv = 1'b1;
            drv_q.delete();
            for (int i = 0; i < 15; i++) begin
                if (!(i >= 7)) lv = ~lv;
                drv_q.push_back(lv ? SJ : SK);
            end
            drv_q.push_back(S0); drv_q.push_back(S0);
            drv_q.push_back(SJ); drv_q.push_back(SJ);
        end
        got_rx.delete(); eop_n = 0; err_n = 0;
        drive_rx();
        repeat (3) @(upd);
        chk(err_n == 1, "R11", err_n, 1, "stuff error pulses");
        chk(got_rx.size() == 0, "R11", got_rx.size(), 0, "bytes after error");
        chk(eop_n == 0, "R11", eop_n, 0, "end pulses after error");

        // R13: SE0 held for the reset length
        drv_q.delete();
        for (int i = 0; i < RST - 1; i++) drv_q.push_back(S0);
        drive_rx();
        @(upd);
        chk(rx_reset == 0, "R13", rx_reset, 0, "reset one sample early");
        {drv_dp, drv_dm} = S0;
        @(upd);
        chk(rx_reset == 1, "R13", rx_reset, 1, "reset at threshold");
        {drv_dp, drv_dm} = SJ;
        @(upd);
        chk(rx_reset == 0, "R13", rx_reset, 0, "reset after J");
        repeat (2) @(upd);

        // recovery after the error: normal packet again (R12)
        pkt_q = {8'h81, 8'h7E};
        run_packet("R9");

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule